// File: doc/BRIEF.md
# Serial Line Rate and Character Format Detector

This block watches an idle-high asynchronous serial input and works out both the bit period and the character format of a sender. Format means the number of data bits and the parity type. The sender transmits one calibration character, a carriage return (code 0x0D, sent LSB first). The block measures the width of the start bit in clock cycles and uses that as the bit period. It then samples the rest of the frame at mid-bit and decides between seven and eight data bits and between no, even and odd parity. It decides from where the trailing ones and the stop bit land in the frame.

A host reads the measured period and the format flags after the single-cycle `done_o` pulse. It uses them to program an external UART. The divisor lookup for that UART lies outside this block. With a 200 MHz clock, a 115.2 kbit/s bit spans 1736 cycles. That fits easily in the default 16-bit counter, which reaches down to about 3.1 kbit/s.

Top module: `abd_autobaud`

## Requirements
- R1: The line passes through a chain of `SYNC_STAGES` flip-flops, which reset to high. A detection starts only on a high-to-low transition of the synchronised line. While the line stays high, `done_o` never pulses.
- R2: On success, `period_o` equals the number of clock cycles the start bit stayed low. This value is the measured bit period T.
- R3: The first sample is taken floor(T/2) cycles after the start bit ends, and the later samples follow every T cycles. Nine samples s0..s8 are always taken. A tenth sample, s9, is taken only when s7 and s8 are both low.
- R4: The format is decoded as follows. If s7=1, the result is 7 data bits with even parity (`len8_o`=0, `parity_o`=01). If s7=0 and s8=1, the result is 8 data bits with no parity (`len8_o`=1, `parity_o`=00). If s7=0 and s8=0, the result is 8 data bits with odd parity (`len8_o`=1, `parity_o`=10). The code 11 never appears.
- R5: If s0..s6 differ from 1,0,1,1,0,0,0 (the low seven bits of 0x0D), the detection ends with `err_o`=1.
- R6: The stop bit is s8 for the 7-bit and the 8-bit no-parity formats, and s9 for the odd-parity format. If the stop bit samples low, the detection ends with `err_o`=1.
- R7: A start bit shorter than `MIN_PERIOD` cycles ends the detection at once with `err_o`=1. A start bit of exactly `MIN_PERIOD` cycles is accepted.
- R8: If the line stays low until the width counter reaches its maximum, 2^`CNT_W`-1, and is still low on the next cycle, the detection ends with `err_o`=1.
- R9: The outputs `err_o`, `period_o`, `len8_o` and `parity_o` change only in a cycle where `done_o` is high. A failed detection leaves `period_o`, `len8_o` and `parity_o` at their previous values. A successful detection clears `err_o`.
- R10: Each detection ends with exactly one `done_o` pulse, one cycle long. The detector then re-arms for the next falling edge.
- R11: After reset, the outputs are `done_o`=0, `err_o`=0, `period_o`=0, `len8_o`=1 and `parity_o`=00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| done_o | output | 1 | One-cycle pulse when a detection ends |
| err_o | output | 1 | The last detection failed; valid from the done pulse |
| period_o | output | CNT_W | Measured bit period in clock cycles |
| len8_o | output | 1 | 1 = eight data bits, 0 = seven |
| parity_o | output | 2 | 00 none, 01 even, 10 odd |

## Verification
The bench builds the block with `CNT_W`=12 and `MIN_PERIOD`=8. The 12-bit counter lets a held-low line saturate after about four thousand cycles, which brings the overflow error into a short run. The same width still holds the 1736-cycle period of 115.2 kbit/s at 200 MHz. The small minimum allows a frame at exactly the minimum period, an odd period that exercises the floored half-period, and a glitch just below the limit.

// File: rtl/abd_pkg.sv
`timescale 1ns/1ps
package abd_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10
  } parity_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEAS,
    ST_SAMP,
    ST_DECIDE
  } state_e;

  // Samples always taken after the start bit (s0..s8)
  localparam int unsigned FRAME_SAMPLES = 9;
  // Position whose level separates 7-bit even from the 8-bit formats
  localparam int unsigned POS_SPLIT     = 7;
  // Position that is stop (7E / 8N) or odd parity (8O)
  localparam int unsigned POS_TAIL      = 8;
  // Low seven bits of the calibration character (carriage return)
  localparam logic [6:0]  CAL_LOW7      = 7'h0D;

endpackage

// File: rtl/abd_line_sync.sv
`timescale 1ns/1ps
module abd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q[0] <= rx_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign rx_s_o = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/abd_bit_timer.sv
`timescale 1ns/1ps
module abd_bit_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wclr_i,
  input  logic             winc_i,
  input  logic             tload_i,
  input  logic [CNT_W-1:0] tval_i,
  output logic [CNT_W-1:0] width_o,
  output logic             wsat_o,
  output logic             tzero_o
);

  localparam logic [CNT_W-1:0] W_MAX = '1;

  logic [CNT_W-1:0] width_q;
  logic [CNT_W-1:0] tmr_q;

  // Start-bit width counter, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '0;
    end else if (wclr_i) begin
      width_q <= CNT_W'(1);
    end else if (winc_i && (width_q != W_MAX)) begin
      width_q <= width_q + CNT_W'(1);
    end
  end

  // Sample countdown, rests at zero
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
    end else if (tload_i) begin
      tmr_q <= tval_i;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - CNT_W'(1);
    end
  end

  assign width_o = width_q;
  assign wsat_o  = (width_q == W_MAX);
  assign tzero_o = (tmr_q == '0);

endmodule

// File: rtl/abd_frame_decode.sv
`timescale 1ns/1ps
module abd_frame_decode
  import abd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       shift_i,
  input  logic       xcap_i,
  input  logic       bit_i,
  output logic       need_extra_o,
  output logic       len8_o,
  output logic [1:0] par_o,
  output logic       data_ok_o,
  output logic       stop_ok_o
);

  logic [FRAME_SAMPLES-1:0] sh_q;
  logic                     xbit_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sh_q   <= '0;
      xbit_q <= 1'b0;
    end else begin
      if (shift_i) begin
        sh_q <= {bit_i, sh_q[FRAME_SAMPLES-1:1]};
      end
      if (xcap_i) begin
        xbit_q <= bit_i;
      end
    end
  end

  assign data_ok_o = (sh_q[6:0] == CAL_LOW7);

  always_comb begin
    need_extra_o = 1'b0;
    if (sh_q[POS_SPLIT]) begin
      len8_o    = 1'b0;
      par_o     = PAR_EVEN;
      stop_ok_o = sh_q[POS_TAIL];
    end else if (sh_q[POS_TAIL]) begin
      len8_o    = 1'b1;
      par_o     = PAR_NONE;
      stop_ok_o = 1'b1;
    end else begin
      need_extra_o = 1'b1;
      len8_o       = 1'b1;
      par_o        = PAR_ODD;
      stop_ok_o    = xbit_q;
    end
  end

endmodule

// File: rtl/abd_autobaud.sv
`timescale 1ns/1ps
module abd_autobaud
  import abd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_PERIOD  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] period_o,
  output logic             len8_o,
  output logic [1:0]       parity_o
);

  localparam int               IDX_W    = $clog2(FRAME_SAMPLES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_SAMPLES - 1);
  localparam logic [CNT_W-1:0] MIN_W    = CNT_W'(MIN_PERIOD);

  logic             rx_s, fall;
  logic [CNT_W-1:0] width;
  logic             wsat, tzero;
  logic             wclr, winc, tload;
  logic [CNT_W-1:0] tval;
  logic             tick, shift_en, x_en;
  logic             need_extra, d_len8, data_ok, stop_ok;
  logic [1:0]       d_par;

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic             extra_q;
  logic [CNT_W-1:0] period_q;

  abd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (fall)
  );

  abd_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .wclr_i  (wclr),
    .winc_i  (winc),
    .tload_i (tload),
    .tval_i  (tval),
    .width_o (width),
    .wsat_o  (wsat),
    .tzero_o (tzero)
  );

  abd_frame_decode u_dec (
    .clk          (clk),
    .rst          (rst),
    .clr_i        (wclr),
    .shift_i      (shift_en),
    .xcap_i       (x_en),
    .bit_i        (rx_s),
    .need_extra_o (need_extra),
    .len8_o       (d_len8),
    .par_o        (d_par),
    .data_ok_o    (data_ok),
    .stop_ok_o    (stop_ok)
  );

  assign tick = (state_q == ST_SAMP) && tzero;

  always_comb begin
    wclr     = (state_q == ST_IDLE) && fall;
    winc     = (state_q == ST_MEAS) && !rx_s;
    tload    = 1'b0;
    tval     = '0;
    if ((state_q == ST_MEAS) && rx_s && (width >= MIN_W)) begin
      tload = 1'b1;
      tval  = (width >> 1) - CNT_W'(1);
    end else if (tick) begin
      tload = 1'b1;
      tval  = period_q - CNT_W'(1);
    end
    shift_en = tick && !extra_q;
    x_en     = tick && extra_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      extra_q  <= 1'b0;
      period_q <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      period_o <= '0;
      len8_o   <= 1'b1;
      parity_o <= PAR_NONE;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fall) state_q <= ST_MEAS;
        end
        ST_MEAS: begin
          if (!rx_s) begin
            if (wsat) begin
              done_o  <= 1'b1;
              err_o   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (width < MIN_W) begin
            done_o  <= 1'b1;
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            period_q <= width;
            idx_q    <= '0;
            extra_q  <= 1'b0;
            state_q  <= ST_SAMP;
          end
        end
        ST_SAMP: begin
          if (tzero) begin
            if (extra_q) begin
              state_q <= ST_DECIDE;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              if (idx_q == IDX_LAST) state_q <= ST_DECIDE;
            end
          end
        end
        ST_DECIDE: begin
          if (need_extra && !extra_q) begin
            extra_q <= 1'b1;
            state_q <= ST_SAMP;
          end else begin
            done_o  <= 1'b1;
            err_o   <= !(data_ok && stop_ok);
            if (data_ok && stop_ok) begin
              period_o <= period_q;
              len8_o   <= d_len8;
              parity_o <= d_par;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/abd_autobaud_chk.sv
`timescale 1ns/1ps
module abd_autobaud_chk #(
  parameter int CNT_W      = 16,
  parameter int MIN_PERIOD = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             done_o,
  input logic             err_o,
  input logic [CNT_W-1:0] period_o,
  input logic             len8_o,
  input logic [1:0]       parity_o
);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r9_period_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(period_o) |-> done_o);

  a_r9_format_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable({len8_o, parity_o}) |-> done_o);

  a_r9_err_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(err_o) |-> done_o);

  a_r4_parity_legal: assert property (@(posedge clk) disable iff (rst)
    parity_o != 2'b11);

  a_r4_seven_is_even: assert property (@(posedge clk) disable iff (rst)
    !len8_o |-> (parity_o == 2'b01));

  a_r7_period_floor: assert property (@(posedge clk) disable iff (rst)
    (period_o == '0) || (period_o >= CNT_W'(MIN_PERIOD)));

endmodule

bind abd_autobaud abd_autobaud_chk #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done_o   (done_o),
  .err_o    (err_o),
  .period_o (period_o),
  .len8_o   (len8_o),
  .parity_o (parity_o)
);

// File: tb/sim_abd_autobaud.sv
`timescale 1ns/1ps
module sim_abd_autobaud;

  localparam int CNT_W = 12;
  localparam int MINP  = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rx  = 1'b1;
  logic             done_o, err_o, len8_o;
  logic [CNT_W-1:0] period_o;
  logic [1:0]       parity_o;

  int n_chk = 0, n_fail = 0, n_done = 0;
  int c_period = 0, c_len8 = 0, c_par = 0, c_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  abd_autobaud #(.CNT_W(CNT_W), .MIN_PERIOD(MINP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .rx_i(rx), .done_o(done_o), .err_o(err_o),
    .period_o(period_o), .len8_o(len8_o), .parity_o(parity_o)
  );

  always @(negedge clk) begin
    if (!rst && done_o) begin
      n_done++;
      c_period = int'(period_o);
      c_len8   = int'(len8_o);
      c_par    = int'(parity_o);
      c_err    = int'(err_o);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // bits[k] is sample sk after the start bit
  task automatic send_frame(input int t, input logic [9:0] bits, input int nb);
    hold(1'b0, t);
    for (int k = 0; k < nb; k++) hold(bits[k], t);
    rx = 1'b1;
  endtask

  task automatic t_reset;
    repeat (40) @(negedge clk);
    chk(n_done == 0, "R1", "done while idle", n_done, 0);
    chk(period_o == 0, "R11", "reset period", int'(period_o), 0);
    chk(len8_o == 1'b1, "R11", "reset len8", int'(len8_o), 1);
    chk(parity_o == 2'b00, "R11", "reset parity", int'(parity_o), 0);
    chk(err_o == 1'b0, "R11", "reset err", int'(err_o), 0);
  endtask

  task automatic t_good(input string req, input int t, input logic [9:0] bits,
                        input int nb, input int e_len8, input int e_par);
    int n0 = n_done;
    send_frame(t, bits, nb);
    hold(1'b1, 4 * t + 20);
    chk(n_done == n0 + 1, "R10", "done count", n_done - n0, 1);
    chk(c_err == 0, req, "err", c_err, 0);
    chk(c_period == t, "R2", "period", c_period, t);
    chk(c_len8 == e_len8, req, "len8", c_len8, e_len8);
    chk(c_par == e_par, req, "parity", c_par, e_par);
  endtask

  // failing detection: results keep the previous values (R9)
  task automatic t_bad(input string req, input int t, input logic [9:0] bits,
                       input int nb);
    int n0 = n_done;
    int p0 = int'(period_o), l0 = int'(len8_o), q0 = int'(parity_o);
    if (t > 0) send_frame(t, bits, nb);
    else hold(1'b0, -t);
    rx = 1'b1;
    hold(1'b1, 200);
    chk(n_done == n0 + 1, req, "done count", n_done - n0, 1);
    chk(c_err == 1, req, "err", c_err, 1);
    chk(c_period == p0, "R9", "period kept", c_period, p0);
    chk(c_len8 == l0 && c_par == q0, "R9", "format kept", c_len8 * 4 + c_par, l0 * 4 + q0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_good("R4", 40, 10'h10D, 9, 1, 0);     // 8 data, no parity
    t_good("R3", 17, 10'h18D, 9, 0, 1);     // 7 data, even, odd period
    t_good("R3", 25, 10'h20D, 10, 1, 2);    // 8 data, odd: tenth sample
    t_good("R7", MINP, 10'h10D, 9, 1, 0);   // exactly the minimum period
    t_bad("R5", 30, 10'h141, 9);            // wrong character
    t_bad("R6", 30, 10'h08D, 9);            // 7E with stop low
    t_bad("R6", 30, 10'h00D, 10);           // 8O with stop low
    t_bad("R7", -(MINP - 3), 10'h000, 0);   // start shorter than minimum
    t_bad("R8", -4200, 10'h000, 0);         // line stuck low
    t_good("R12", 1736, 10'h10D, 9, 1, 0);  // 115.2 kbit/s at 200 MHz
    chk(err_o == 1'b0, "R9", "err cleared", int'(err_o), 0);
    t_good("R4", 33, 10'h18D, 9, 0, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule